// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address used on each cycle of a short fixed-length burst. On a load cycle it captures an external start address together with the transfer direction; on each following advance cycle it steps an internal beat counter and derives the next word address from the captured start address. The upper address bits stay fixed for the whole burst; only the low beat-select bits move, in either linear or interleaved order as chosen by a static order-select input.

A qualified chip-select tells the sequencer whether a load cycle starts a burst or ends one. A suspend input freezes all state, so the surrounding logic can stall the pipeline for any number of cycles. The captured direction is held for every beat so that later stages need not see it again.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and directly after it, `burst_act` is 0, `word_addr` is 0 and `wr_dir` is 0.
- R2: With `interleave` = 0, beat k of a burst (k = 0..3) presents low two address bits equal to (start low bits + k) mod 4.
- R3: With `interleave` = 1, beat k presents low two address bits equal to (start low bits) XOR k.
- R4: During advance cycles the bits of `word_addr` above the low two stay equal to the loaded start address, and `ext_addr` has no effect.
- R5: A non-suspended cycle with `adv_ld` = 0 and `chip_sel` = 1 makes `word_addr` equal `ext_addr`, `burst_act` 1 and `wr_dir` equal `wr_in` from the next cycle.
- R6: An advance after the fourth beat returns `word_addr` to the first beat's address and the burst continues.
- R7: A non-suspended cycle with `adv_ld` = 0 and `chip_sel` = 0 clears `burst_act` from the next cycle.
- R8: While `suspend` = 1, `word_addr`, `burst_act` and `wr_dir` keep their values whatever the other inputs do.
- R9: An advance (`adv_ld` = 1) while `burst_act` = 0 changes nothing: `burst_act` stays 0 and `word_addr` holds.
- R10: `wr_dir` keeps the value captured on the load cycle for every beat of the burst; `wr_in` on advance cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend | input | 1 | 1 freezes all sequencer state for this cycle |
| adv_ld | input | 1 | 0 = load / end cycle, 1 = advance cycle |
| chip_sel | input | 1 | Qualified select, 1 = selected; used on load cycles |
| wr_in | input | 1 | Direction for a load cycle, 1 = write |
| interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | Start word address for a load cycle |
| word_addr | output | ADDR_W | Word address of the current beat |
| burst_act | output | 1 | 1 while a burst is in progress |
| wr_dir | output | 1 | Direction captured on the last load |

## Verification
The assertions assume `interleave` only changes while no burst is running, since the linear-step property compares consecutive beat addresses under one order; the stimulus changes it only after a deselect cycle. They also assume the inputs are known at every sampled edge after reset, which holds because the bench drives every input on each falling edge. Interleaved ordering is checked by the scoreboard, which predicts each beat's address from the start address and its own beat count.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_STOP = 2'd2,
    OP_STEP = 2'd3
  } bsq_op_t;
endpackage

// File: rtl/bsq_decode.sv
module bsq_decode
  import bsq_pkg::*;
(
  input  logic    suspend,
  input  logic    adv_ld,
  input  logic    chip_sel,
  input  logic    active,
  output bsq_op_t op
);
  always_comb begin
    op = OP_IDLE;
    if (!suspend) begin
      if (!adv_ld) begin
        op = chip_sel ? OP_LOAD : OP_STOP;
      end else if (active) begin
        op = OP_STEP;
      end
    end
  end
endmodule

// File: rtl/bsq_order.sv
module bsq_order #(
  parameter int BEAT_W = 2
) (
  input  logic              interleave,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lo_out
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  always_comb begin
    lin_lo = start_lo + beat;
    ilv_lo = start_lo ^ beat;
    lo_out = interleave ? ilv_lo : lin_lo;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              adv_ld,
  input  logic              chip_sel,
  input  logic              wr_in,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_act,
  output logic              wr_dir
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [BEAT_W-1:0] lo_sel;
  bsq_op_t           op;

  bsq_decode u_dec (
    .suspend  (suspend),
    .adv_ld   (adv_ld),
    .chip_sel (chip_sel),
    .active   (act_q),
    .op       (op)
  );

  bsq_order #(.BEAT_W(BEAT_W)) u_ord (
    .interleave (interleave),
    .start_lo   (base_q[BEAT_W-1:0]),
    .beat       (beat_q),
    .lo_out     (lo_sel)
  );

  // next-state
  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    act_d  = act_q;
    wr_d   = wr_q;
    unique case (op)
      OP_LOAD: begin
        base_d = ext_addr;
        beat_d = '0;
        act_d  = 1'b1;
        wr_d   = wr_in;
      end
      OP_STOP: begin
        beat_d = '0;
        act_d  = 1'b0;
      end
      OP_STEP: beat_d = beat_q + 1'b1;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      act_q  <= act_d;
      wr_q   <= wr_d;
    end
  end

  assign word_addr = {base_q[ADDR_W-1:BEAT_W], lo_sel};
  assign burst_act = act_q;
  assign wr_dir    = wr_q;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              suspend,
  input logic              adv_ld,
  input logic              chip_sel,
  input logic              wr_in,
  input logic              interleave,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] word_addr,
  input logic              burst_act,
  input logic              wr_dir
);
  localparam int BW = $clog2(BURST_LEN);

  always_comb begin
    if (!rst_n) begin
      a_r1_reset: assert (!burst_act && word_addr == '0 && !wr_dir);
    end
  end

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !adv_ld && chip_sel) |=>
      (word_addr == $past(ext_addr) && burst_act && wr_dir == $past(wr_in)));

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !adv_ld && !chip_sel) |=> !burst_act);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> ($stable(burst_act) && $stable(wr_dir) && $stable(word_addr)));

  a_r9_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv_ld && !burst_act) |=> (!burst_act && $stable(word_addr)));

  a_r4_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv_ld && burst_act) |=>
      (word_addr[ADDR_W-1:BW] == $past(word_addr[ADDR_W-1:BW])));

  a_r10_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv_ld) |=> $stable(wr_dir));

  a_r2_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && adv_ld && burst_act && !interleave && $stable(interleave)) |=>
      (word_addr[BW-1:0] == BW'($past(word_addr[BW-1:0]) + 1'b1)));
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend), .adv_ld(adv_ld),
  .chip_sel(chip_sel), .wr_in(wr_in), .interleave(interleave),
  .ext_addr(ext_addr), .word_addr(word_addr), .burst_act(burst_act),
  .wr_dir(wr_dir)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          suspend, adv_ld, chip_sel, wr_in, interleave;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] word_addr;
  logic          burst_act, wr_dir;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          act;
    logic          wr;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_act  = 1'b0;
  logic          m_wr   = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .suspend(suspend), .adv_ld(adv_ld),
    .chip_sel(chip_sel), .wr_in(wr_in), .interleave(interleave),
    .ext_addr(ext_addr), .word_addr(word_addr), .burst_act(burst_act),
    .wr_dir(wr_dir)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (word_addr !== e.addr || burst_act !== e.act || wr_dir !== e.wr) begin
      fails++;
      $display("FAIL %s: addr=%h act=%b wr=%b expected addr=%h act=%b wr=%b",
               e.tag, word_addr, burst_act, wr_dir, e.addr, e.act, e.wr);
    end
  endtask

  // driver: one cycle of stimulus, model predicts the state after the edge
  task automatic step(input logic adv, input logic sel, input logic wr,
                      input logic susp, input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic [1:0] lo;
    @(negedge clk);
    adv_ld = adv; chip_sel = sel; wr_in = wr; suspend = susp; ext_addr = a;
    if (!susp) begin
      if (!adv) begin
        if (sel) begin
          m_base = a; m_beat = 2'd0; m_act = 1'b1; m_wr = wr;
        end else begin
          m_act = 1'b0; m_beat = 2'd0;
        end
      end else if (m_act) begin
        m_beat = m_beat + 2'd1;
      end
    end
    lo = interleave ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    e.addr = {m_base[AW-1:2], lo};
    e.act  = m_act;
    e.wr   = m_wr;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; suspend = 1'b0; adv_ld = 1'b1; chip_sel = 1'b0;
    wr_in = 1'b0; interleave = 1'b0; ext_addr = '0;
    #12;
    r.addr = '0; r.act = 1'b0; r.wr = 1'b0; r.tag = "R1 reset";
    compare(r);
    @(negedge clk); rst_n = 1'b1;

    // R9: advance with nothing active
    step(1, 1, 1, 0, 17'h1ABCD, "R9 idle advance");
    step(1, 0, 0, 0, 17'h00F0F, "R9 idle advance");

    // R5 load, R2 linear beats, R6 wrap, R4 ext_addr ignored, R10 wr_in ignored
    step(0, 1, 1, 0, 17'h12346, "R5 load write");
    step(1, 1, 0, 0, 17'h0AAAA, "R2 linear beat1 R4 R10");
    step(1, 0, 0, 0, 17'h15555, "R2 linear beat2 R4");
    step(1, 1, 0, 0, 17'h00000, "R2 linear beat3 R10");
    step(1, 1, 1, 0, 17'h1FFFF, "R6 wrap to first");
    // R8 suspend mid-burst, including a would-be load
    step(1, 1, 0, 1, 17'h00000, "R8 hold on advance");
    step(0, 1, 0, 1, 17'h0F00F, "R8 hold on load");
    step(0, 0, 0, 1, 17'h0F00F, "R8 hold on stop");
    step(1, 1, 0, 0, 17'h00000, "R2 after suspend");
    // R7 end burst
    step(0, 0, 1, 0, 17'h1FFFF, "R7 deselect ends");
    step(1, 1, 1, 0, 17'h00001, "R9 advance after end");

    // R3 interleaved order, start low bits 1
    @(negedge clk); interleave = 1'b1;
    step(0, 1, 0, 0, 17'h0BEE1, "R5 load read");
    step(1, 1, 1, 0, 17'h00000, "R3 ilv beat1 R10");
    step(1, 1, 1, 0, 17'h00000, "R3 ilv beat2");
    step(1, 1, 1, 0, 17'h00000, "R3 ilv beat3");
    step(1, 1, 1, 0, 17'h00000, "R6 ilv wrap");
    // reload mid-burst at start low bits 3
    step(0, 1, 1, 0, 17'h13C03, "R5 reload");
    step(1, 0, 0, 0, 17'h00000, "R3 ilv start3 beat1");
    step(1, 0, 0, 0, 17'h00000, "R3 ilv start3 beat2");
    step(1, 0, 0, 0, 17'h00000, "R3 ilv start3 beat3 R4");
    step(0, 0, 0, 0, 17'h00000, "R7 deselect");

    // back to linear, start low bits 3
    @(negedge clk); interleave = 1'b0;
    step(0, 1, 0, 0, 17'h00007, "R5 load");
    step(1, 1, 1, 0, 17'h10000, "R2 lin start3 beat1");
    step(1, 1, 1, 0, 17'h10000, "R2 lin start3 beat2");
    step(1, 1, 1, 0, 17'h10000, "R2 lin start3 beat3");
    step(1, 1, 1, 0, 17'h10000, "R6 lin wrap");

    step(1, 0, 0, 1, 17'h00000, "R8 final hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule